// File: doc/BRIEF.md
# Ring Message Send/Receive Unit

This unit lets a core exchange short messages with other cores over a slotted ring. Each cycle one slot passes through the unit. A slot has a 2-bit kind (0 = Null, 1 = Message, 2 and 3 = other ring traffic), a 4-bit node field and a 32-bit word. The ring path is one register deep. A slot that arrives at one clock edge leaves on the ring outputs right after the next edge, either unchanged, freed to Null, or replaced by an outgoing message slot.

To send, the core presents a destination, a 4-bit message type and a length of 0 to 63 on a start pulse. The unit then fills free ring slots with:
- one header word;
- one slot per body word, which the core provides on request by index.

To receive, the unit watches every slot for Message slots whose node field equals its own identifier. It frees each slot it consumes and queues the word in a deep receive FIFO, which the core polls. A header with length zero is not queued. It is handed to a debug strobe output instead.

Top module: `ring_msg_unit`

## Requirements
- R1: A header slot has kind 1 (Message) and node = destination. Its word carries the sender's `self_id` in bits [13:10], the type in bits [9:6] and the length in bits [5:0], with bits [31:14] zero.
- R2: The header is followed by exactly `length` body slots of kind 1 with node = destination, in index order 0 .. length-1. Each carries the `tx_word` value present while `tx_word_idx` shows that index.
- R3: The sender places a slot only where the incoming slot has kind 0 (Null). It waits as long as needed and never reorders words.
- R4: A slot that the unit neither consumes nor replaces appears on the ring outputs unchanged one cycle after it arrives.
- R5: A consumed slot leaves as kind 0 (Null) one cycle after it arrives.
- R6: Headers with nonzero length and their body words, addressed to this node, are stored in arrival order. `rd_word` shows the oldest stored word and `rd_empty` shows that none is stored. A `rd_pop` pulse removes the oldest word, and a `rd_pop` while empty has no effect.
- R7: A header of length zero addressed to this node is consumed without entering the FIFO. `dbg_valid` pulses for one cycle with `dbg_word` holding the header word, one cycle after the slot arrives.
- R8: When the FIFO is full, an arriving Message slot for this node is forwarded unchanged and not stored. The same message is accepted once space frees.
- R9: While reset is asserted, the ring output kind is Null, `rd_empty` is 1, `tx_busy` is 0 and `dbg_valid` is 0.
- R10: A `tx_start` while `tx_busy` is high is ignored, and the message in flight is unchanged.
- R11: A send of length zero emits only the header, then `tx_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| self_id | input | 4 | This node's ring identifier |
| ring_in_kind | input | 2 | Incoming slot kind |
| ring_in_node | input | 4 | Incoming slot node field |
| ring_in_word | input | 32 | Incoming slot word |
| ring_out_kind | output | 2 | Outgoing slot kind |
| ring_out_node | output | 4 | Outgoing slot node field |
| ring_out_word | output | 32 | Outgoing slot word |
| tx_start | input | 1 | Start a message send |
| tx_dest | input | 4 | Destination node |
| tx_kind | input | 4 | Message type |
| tx_len | input | 6 | Body length in words |
| tx_word | input | 32 | Body word for the index on tx_word_idx |
| tx_word_idx | output | 6 | Index of the body word being sent |
| tx_busy | output | 1 | A send is in progress |
| rd_pop | input | 1 | Remove the oldest received word |
| rd_word | output | 32 | Oldest received word |
| rd_empty | output | 1 | No received word available |
| dbg_valid | output | 1 | Zero-length header received |
| dbg_word | output | 32 | The zero-length header word |

## Verification
The assertions assume that messages addressed to this node arrive one at a time: one header, then its body slots, with no other message to this node in between. They also assume the core keeps `tx_word` a pure function of `tx_word_idx` for the message in flight. The stimulus respects both. Background traffic is random Null slots, other-kind slots and Message slots for other nodes, so it never targets this node while a received message is being assembled. The body-word function is fixed per message from the bench's stored destination and type.

// File: rtl/ring_msg_pkg.sv
package ring_msg_pkg;
    localparam int NODE_W = 4;
    localparam int KIND_W = 4;
    localparam int LEN_W  = 6;
    localparam int WORD_W = 32;

    localparam int HDR_LEN_LSB  = 0;
    localparam int HDR_KIND_LSB = HDR_LEN_LSB + LEN_W;
    localparam int HDR_SRC_LSB  = HDR_KIND_LSB + KIND_W;

    typedef enum logic [1:0] {
        SLOT_NULL  = 2'd0,
        SLOT_MSG   = 2'd1,
        SLOT_OTH_A = 2'd2,
        SLOT_OTH_B = 2'd3
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e          kind;
        logic [NODE_W-1:0]   node;
        logic [WORD_W-1:0]   word;
    } ring_slot_t;
endpackage

// File: rtl/ring_msg_fifo.sv
module ring_msg_fifo #(
    parameter int DEPTH = 1024,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_regs_t;

    fifo_regs_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic pop_eff;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == CW'(DEPTH));
    assign pop_eff = pop && !empty;
    assign rdata   = mem[q.rd];

    always_comb begin
        d = q;
        if (push) d.wr = bump(q.wr);
        if (pop_eff) d.rd = bump(q.rd);
        case ({push, pop_eff})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[q.wr] <= wdata;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R8
    AST_COUNT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(push && !pop_eff)) |-> q.cnt == $past(q.cnt) + 1'b1); // R6
    AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(empty && !push)) |-> $stable(q.rd)); // R6
endmodule

// File: rtl/ring_msg_tx.sv
module ring_msg_tx
    import ring_msg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NODE_W-1:0] self_id,
    input  logic              start,
    input  logic [NODE_W-1:0] dest,
    input  logic [KIND_W-1:0] kind,
    input  logic [LEN_W-1:0]  len,
    input  logic [WORD_W-1:0] body_word,
    input  logic              slot_free,
    output logic              place,
    output ring_slot_t        slot,
    output logic              busy,
    output logic [LEN_W-1:0]  body_idx
);
    typedef enum logic [1:0] {TX_IDLE, TX_HEAD, TX_BODY} tx_state_e;

    typedef struct packed {
        tx_state_e         st;
        logic [NODE_W-1:0] dest;
        logic [KIND_W-1:0] kind;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  idx;
    } tx_regs_t;

    tx_regs_t q, d;
    logic [WORD_W-1:0] hdr_word;

    always_comb begin
        hdr_word = '0;
        hdr_word[HDR_SRC_LSB  +: NODE_W] = self_id;
        hdr_word[HDR_KIND_LSB +: KIND_W] = q.kind;
        hdr_word[HDR_LEN_LSB  +: LEN_W]  = q.len;
    end

    always_comb begin
        d          = q;
        place      = 1'b0;
        slot.kind  = SLOT_MSG;
        slot.node  = q.dest;
        slot.word  = hdr_word;
        case (q.st)
            TX_IDLE: begin
                if (start) begin
                    d.st   = TX_HEAD;
                    d.dest = dest;
                    d.kind = kind;
                    d.len  = len;
                    d.idx  = '0;
                end
            end
            TX_HEAD: begin
                if (slot_free) begin
                    place = 1'b1;
                    d.st  = (q.len == '0) ? TX_IDLE : TX_BODY;
                end
            end
            TX_BODY: begin
                slot.word = body_word;
                if (slot_free) begin
                    place = 1'b1;
                    d.idx = q.idx + 1'b1;
                    if ((q.idx + 1'b1) == q.len) d.st = TX_IDLE;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: TX_IDLE, default: '0};
        else        q <= d;
    end

    assign busy     = (q.st != TX_IDLE);
    assign body_idx = q.idx;

    AST_BODY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(place && q.st == TX_BODY && (q.idx + 1'b1) != q.len))
        |-> q.idx == $past(q.idx) + 1'b1); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(q.len) && $stable(q.dest) && $stable(q.kind))); // R10
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !slot_free) |=> ($stable(q.idx) && $stable(q.st))); // R3
endmodule

// File: rtl/ring_msg_rx.sv
module ring_msg_rx
    import ring_msg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NODE_W-1:0] self_id,
    input  ring_slot_t        in_slot,
    input  logic              fifo_full,
    output logic              take,
    output logic              push,
    output logic [WORD_W-1:0] push_word,
    output logic              dbg_valid,
    output logic [WORD_W-1:0] dbg_word
);
    typedef struct packed {
        logic [LEN_W-1:0]  rem;
        logic              dbg_v;
        logic [WORD_W-1:0] dbg_w;
    } rx_regs_t;

    rx_regs_t q, d;
    logic mine;
    logic [LEN_W-1:0] hdr_len;

    assign mine      = (in_slot.kind == SLOT_MSG) && (in_slot.node == self_id);
    assign hdr_len   = in_slot.word[HDR_LEN_LSB +: LEN_W];
    assign push_word = in_slot.word;

    always_comb begin
        d       = q;
        d.dbg_v = 1'b0;
        take    = 1'b0;
        push    = 1'b0;
        if (mine) begin
            if (q.rem == '0 && hdr_len == '0) begin
                take    = 1'b1;
                d.dbg_v = 1'b1;
                d.dbg_w = in_slot.word;
            end else if (!fifo_full) begin
                take  = 1'b1;
                push  = 1'b1;
                d.rem = (q.rem == '0) ? hdr_len : q.rem - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dbg_valid = q.dbg_v;
    assign dbg_word  = q.dbg_w;

    AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !push); // R8
    AST_ZERO_LEN_DBG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(take && !push)) |-> dbg_valid); // R7
endmodule

// File: rtl/ring_msg_unit.sv
module ring_msg_unit
    import ring_msg_pkg::*;
#(
    parameter int FIFO_DEPTH = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  self_id,
    input  logic [1:0]  ring_in_kind,
    input  logic [3:0]  ring_in_node,
    input  logic [31:0] ring_in_word,
    output logic [1:0]  ring_out_kind,
    output logic [3:0]  ring_out_node,
    output logic [31:0] ring_out_word,
    input  logic        tx_start,
    input  logic [3:0]  tx_dest,
    input  logic [3:0]  tx_kind,
    input  logic [5:0]  tx_len,
    input  logic [31:0] tx_word,
    output logic [5:0]  tx_word_idx,
    output logic        tx_busy,
    input  logic        rd_pop,
    output logic [31:0] rd_word,
    output logic        rd_empty,
    output logic        dbg_valid,
    output logic [31:0] dbg_word
);
    ring_slot_t in_slot, tx_slot, out_d, out_q;
    logic take, place, push, fifo_full;
    logic [WORD_W-1:0] push_word;

    always_comb begin
        in_slot.kind = slot_kind_e'(ring_in_kind);
        in_slot.node = ring_in_node;
        in_slot.word = ring_in_word;
    end

    ring_msg_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .self_id   (self_id),
        .start     (tx_start),
        .dest      (tx_dest),
        .kind      (tx_kind),
        .len       (tx_len),
        .body_word (tx_word),
        .slot_free (in_slot.kind == SLOT_NULL),
        .place     (place),
        .slot      (tx_slot),
        .busy      (tx_busy),
        .body_idx  (tx_word_idx)
    );

    ring_msg_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .self_id   (self_id),
        .in_slot   (in_slot),
        .fifo_full (fifo_full),
        .take      (take),
        .push      (push),
        .push_word (push_word),
        .dbg_valid (dbg_valid),
        .dbg_word  (dbg_word)
    );

    ring_msg_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (push_word),
        .pop   (rd_pop),
        .rdata (rd_word),
        .empty (rd_empty),
        .full  (fifo_full)
    );

    always_comb begin
        if (take) begin
            out_d.kind = SLOT_NULL;
            out_d.node = '0;
            out_d.word = '0;
        end else if (place) begin
            out_d = tx_slot;
        end else begin
            out_d = in_slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{kind: SLOT_NULL, default: '0};
        else        out_q <= out_d;
    end

    assign ring_out_kind = out_q.kind;
    assign ring_out_node = out_q.node;
    assign ring_out_word = out_q.word;

    AST_TAKEN_FREED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(take)) |-> ring_out_kind == SLOT_NULL); // R5
    AST_FORWARD_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!take && !place)) |-> out_q == $past(in_slot)); // R4
    AST_PLACE_ON_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(place)) |-> ($past(in_slot.kind) == SLOT_NULL && ring_out_kind == SLOT_MSG)); // R3
endmodule

// File: tb/ring_msg_unit_bench.sv
module ring_msg_unit_bench;
    localparam int DEPTH = 16;
    localparam logic [3:0] ME = 4'd5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [1:0]  ring_in_kind;
    logic [3:0]  ring_in_node;
    logic [31:0] ring_in_word;
    logic [1:0]  ring_out_kind;
    logic [3:0]  ring_out_node;
    logic [31:0] ring_out_word;
    logic        tx_start;
    logic [3:0]  tx_dest, tx_kind;
    logic [5:0]  tx_len;
    logic [31:0] tx_word;
    logic [5:0]  tx_word_idx;
    logic        tx_busy;
    logic        rd_pop;
    logic [31:0] rd_word;
    logic        rd_empty;
    logic        dbg_valid;
    logic [31:0] dbg_word;

    logic [3:0] cur_dest, cur_kind;

    function automatic logic [31:0] body_fn(input logic [3:0] d, input logic [3:0] k, input logic [5:0] i);
        return {8'hC3, d, k, 10'h0, i};
    endfunction

    function automatic logic [31:0] hdr_fn(input logic [3:0] s, input logic [3:0] k, input logic [5:0] l);
        return {18'h0, s, k, l};
    endfunction

    assign tx_word = body_fn(cur_dest, cur_kind, tx_word_idx);

    ring_msg_unit #(.FIFO_DEPTH(DEPTH)) u_ring_msg_unit (
        .clk(clk), .rst_n(rst_n), .self_id(ME),
        .ring_in_kind(ring_in_kind), .ring_in_node(ring_in_node), .ring_in_word(ring_in_word),
        .ring_out_kind(ring_out_kind), .ring_out_node(ring_out_node), .ring_out_word(ring_out_word),
        .tx_start(tx_start), .tx_dest(tx_dest), .tx_kind(tx_kind), .tx_len(tx_len),
        .tx_word(tx_word), .tx_word_idx(tx_word_idx), .tx_busy(tx_busy),
        .rd_pop(rd_pop), .rd_word(rd_word), .rd_empty(rd_empty),
        .dbg_valid(dbg_valid), .dbg_word(dbg_word)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    // ring monitor: compares each outgoing slot with the slot that entered one cycle before
    logic [35:0] seen_q [$];
    bit          mon_en = 0;
    logic [1:0]  pk;
    logic [3:0]  pn;
    logic [31:0] pw;
    always @(posedge clk) begin
        if (mon_en) begin
            pk = ring_in_kind; pn = ring_in_node; pw = ring_in_word;
            #1;
            if (pk == 2'd0) begin
                if (ring_out_kind == 2'd1) seen_q.push_back({ring_out_node, ring_out_word});
                else chk(ring_out_kind == 2'd0, "R3", 64'(ring_out_kind), 64'd0);
            end else if (pk == 2'd1 && pn == ME) begin
                chk(ring_out_kind == 2'd0 ||
                    (ring_out_kind == pk && ring_out_node == pn && ring_out_word == pw),
                    "R5", {ring_out_kind, ring_out_node, ring_out_word}, {pk, pn, pw});
            end else begin
                chk(ring_out_kind == pk && ring_out_node == pn && ring_out_word == pw,
                    "R4", {ring_out_kind, ring_out_node, ring_out_word}, {pk, pn, pw});
            end
        end
    end

    task automatic set_null();
        ring_in_kind = 2'd0; ring_in_node = 4'd0; ring_in_word = 32'd0;
    endtask

    task automatic bg_cycle();
        int r;
        r = int'($urandom % 4);
        if (r < 2) begin
            set_null();
        end else if (r == 2) begin
            ring_in_kind = 2'd2 + 2'($urandom % 2);
            ring_in_node = 4'($urandom);
            ring_in_word = $urandom;
        end else begin
            ring_in_kind = 2'd1;
            ring_in_node = ME + 4'd1 + 4'($urandom % 15);
            ring_in_word = $urandom;
        end
        @(negedge clk);
    endtask

    task automatic put_slot(input logic [1:0] k, input logic [3:0] n, input logic [31:0] w);
        ring_in_kind = k; ring_in_node = n; ring_in_word = w;
        @(negedge clk);
        set_null();
    endtask

    task automatic send_msg(input logic [3:0] d, input logic [3:0] k, input logic [5:0] l, input bit poke);
        logic [35:0] exp [$];
        cur_dest = d; cur_kind = k;
        tx_dest = d; tx_kind = k; tx_len = l; tx_start = 1'b1;
        bg_cycle();
        tx_start = 1'b0;
        if (poke) begin
            // R10: second start while busy must be ignored
            tx_dest = ~d; tx_kind = ~k; tx_len = l + 6'd1; tx_start = 1'b1;
            bg_cycle();
            tx_start = 1'b0;
        end
        while (tx_busy) bg_cycle();
        set_null();
        repeat (2) @(negedge clk);
        exp.push_back({d, hdr_fn(ME, k, l)});
        for (int i = 0; i < int'(l); i++) exp.push_back({d, body_fn(d, k, 6'(i))});
        chk(seen_q.size() == exp.size(), (l == 0) ? "R11" : "R2", 64'(seen_q.size()), 64'(exp.size()));
        for (int i = 0; i < exp.size() && i < seen_q.size(); i++)
            chk(seen_q[i] == exp[i], (i == 0) ? "R1" : "R2", 64'(seen_q[i]), 64'(exp[i]));
        seen_q.delete();
    endtask

    logic [31:0] fifo_exp [$];

    task automatic rx_msg(input logic [3:0] s, input logic [3:0] k, input logic [5:0] l);
        logic [31:0] h, w;
        h = hdr_fn(s, k, l);
        put_slot(2'd1, ME, h);
        if (l == 6'd0) begin
            chk(dbg_valid == 1'b1 && dbg_word == h, "R7", {31'd0, dbg_valid, dbg_word}, {31'd0, 1'b1, h});
            chk(rd_empty == 1'b1 || fifo_exp.size() != 0, "R7", 64'(rd_empty), 64'd1);
            @(negedge clk);
            chk(dbg_valid == 1'b0, "R7", 64'(dbg_valid), 64'd0);
        end else begin
            fifo_exp.push_back(h);
            for (int i = 0; i < int'(l); i++) begin
                repeat ($urandom % 3) bg_cycle();
                w = $urandom;
                put_slot(2'd1, ME, w);
                fifo_exp.push_back(w);
            end
        end
    endtask

    task automatic drain();
        while (fifo_exp.size() != 0) begin
            chk(!rd_empty && rd_word == fifo_exp[0], "R6", {31'd0, rd_empty, rd_word}, {32'd0, fifo_exp[0]});
            rd_pop = 1'b1;
            @(negedge clk);
            rd_pop = 1'b0;
            void'(fifo_exp.pop_front());
        end
        chk(rd_empty == 1'b1, "R6", 64'(rd_empty), 64'd1);
    endtask

    initial begin
        logic [31:0] hfull;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; tx_start = 1'b0; tx_dest = '0; tx_kind = '0; tx_len = '0;
        rd_pop = 1'b0; cur_dest = '0; cur_kind = '0;
        set_null();
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(ring_out_kind == 2'd0, "R9", 64'(ring_out_kind), 64'd0);
        chk(rd_empty == 1'b1, "R9", 64'(rd_empty), 64'd1);
        chk(tx_busy == 1'b0, "R9", 64'(tx_busy), 64'd0);
        chk(dbg_valid == 1'b0, "R9", 64'(dbg_valid), 64'd0);
        rst_n = 1'b1;
        mon_en = 1;
        @(negedge clk);

        // directed sends
        send_msg(4'd9, 4'd3, 6'd4, 1'b0);
        send_msg(4'd2, 4'd7, 6'd0, 1'b0);   // R11 zero-length send
        send_msg(4'd12, 4'd1, 6'd63, 1'b0); // longest body
        send_msg(4'd3, 4'd15, 6'd5, 1'b1);  // R10 start while busy
        for (int m = 0; m < 6; m++)
            send_msg(4'($urandom), 4'($urandom), 6'($urandom % 20), 1'($urandom % 2));

        // pop while empty is ignored (R6)
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        chk(rd_empty == 1'b1, "R6", 64'(rd_empty), 64'd1);

        // receive: directed then random
        rx_msg(4'd1, 4'd2, 6'd3);
        drain();
        rx_msg(4'd7, 4'd4, 6'd0);           // R7 zero-length header
        chk(rd_empty == 1'b1, "R7", 64'(rd_empty), 64'd1);
        for (int m = 0; m < 10; m++) begin
            rx_msg(4'($urandom), 4'($urandom), 6'($urandom % 12));
            drain();
        end

        // R8: fill the FIFO, then a further header must be forwarded unchanged
        rx_msg(4'd8, 4'd6, 6'(DEPTH - 1));
        hfull = hdr_fn(4'd8, 4'd9, 6'd1);
        put_slot(2'd1, ME, hfull);
        chk(ring_out_kind == 2'd1 && ring_out_node == ME && ring_out_word == hfull, "R8",
            {ring_out_kind, ring_out_node, ring_out_word}, {2'd1, ME, hfull});
        drain();
        rx_msg(4'd8, 4'd9, 6'd1);           // R8: accepted once space is free
        drain();

        set_null();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule